// File: doc/BRIEF.md
# Instruction-Countdown Mode Controller

This block holds a 32-bit mode-control word for a processor core. The low byte enables extension modes, and the next byte is a countdown. When software writes a nonzero countdown together with some mode bits, those modes stay active only for that many retired instructions. After the last of them the modes switch off by themselves, so no second write is needed to leave the mode. A countdown of zero makes the modes persistent.

The pipeline sends the block one retire strobe per completed instruction. With each strobe come two decode facts: whether the instruction changes the PC non-sequentially, and which extension modes it depends on. From these the block raises a one-cycle illegal-instruction trap request in three cases: a PC redirect while a countdown is running, a dependence on a mode the build does not implement, and a mode-dependent instruction while an unimplemented mode bit is set. The whole word is always visible on a save port, so trap-entry logic can store it. A restore strobe reloads it on trap return, countdown included.

Top module: `mode_countdown_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the whole word to zero, and trap_req to zero, by the cycle after reset.
- R2: A write loads the full 32-bit word on the next clock edge. Bits [7:0] are the mode enables, bits [15:8] are the countdown, and bits [31:16] are held unchanged. save_word shows the stored word and mode_out shows bits [7:0].
- R3: Each accepted retire with a countdown above 1 lowers the countdown by exactly one and leaves the mode bits unchanged. A cycle without retire changes nothing. With a countdown of 0, retires leave the word unchanged (persistent mode).
- R4: An accepted retire with a countdown of 1 sets both the countdown and the mode bits to zero on the same edge.
- R5: A retire in the same cycle as a write or a restore is ignored: it is not counted and cannot trap.
- R6: A retire with redirect high while the countdown is nonzero raises trap_req on the next cycle and leaves the word unchanged. With a countdown of zero, a redirect does not trap.
- R7: A retire whose need_mode has any bit outside the supported mask (default 8'h0F) raises trap_req on the next cycle.
- R8: A write that sets unsupported mode bits is accepted as written. After it, a retire with need_mode zero does not trap, and a retire with any need_mode bit set does trap.
- R9: trap_req lasts exactly one cycle. During that cycle retires are ignored and save_word still shows the word from before the trapping instruction.
- R10: A restore loads the full word from restore_data on the next edge. It takes priority over a simultaneous write, retire or trap cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the mode-control word |
| wr_data | input | 32 | Word to write |
| retire | input | 1 | One instruction retires this cycle |
| redirect | input | 1 | The retiring instruction changes the PC non-sequentially |
| need_mode | input | 8 | Mode bits the retiring instruction depends on |
| restore_en | input | 1 | Trap-return reload strobe |
| restore_data | input | 32 | Word to reload |
| mode_out | output | 8 | Currently enabled mode bits |
| save_word | output | 32 | Current mode-control word, for trap-entry save |
| trap_req | output | 1 | One-cycle illegal-instruction trap request |

## Verification
The assertions assume that retire, redirect and need_mode describe one instruction and hold steady across each sampling edge. They also assume that rst, wr_en and restore_en are plain synchronous strobes. The bench changes every input two nanoseconds after a rising edge and reads outputs at the same point, so each edge sees one settled set of inputs. The trap path is swept over all 256 need_mode values. Countdowns from 1 to 12 are swept with stall cycles inserted between retires, so every decrement and the expiry edge are checked against arithmetic in the bench.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int REG_W  = 32;
  localparam int MODE_W = 8;
  localparam int CNT_W  = 8;
  localparam int REST_W = REG_W - MODE_W - CNT_W;

  typedef struct packed {
    logic [REST_W-1:0] rest;
    logic [CNT_W-1:0]  cnt;
    logic [MODE_W-1:0] mode;
  } mcd_word_t;
endpackage

// File: rtl/mcd_illegal.sv
module mcd_illegal
  import mcd_pkg::*;
#(
  parameter logic [MODE_W-1:0] SUPPORTED = 8'h0F
) (
  input  logic              instr_ok,
  input  logic              redirect,
  input  logic [MODE_W-1:0] need_mode,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic              illegal
);
  logic counting;
  logic need_unsup;
  logic held_unsup;

  always_comb begin
    counting   = |cur_cnt;
    need_unsup = |(need_mode & ~SUPPORTED);
    held_unsup = (|need_mode) && (|(cur_mode & ~SUPPORTED));
    illegal    = instr_ok && ((redirect && counting) || need_unsup || held_unsup);
  end
endmodule

// File: rtl/mcd_state.sv
module mcd_state
  import mcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      restore_en,
  input  mcd_word_t restore_word,
  input  logic      load_en,
  input  mcd_word_t load_word,
  input  logic      step,
  output mcd_word_t cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (restore_en) begin
      cur <= restore_word;
    end else if (load_en) begin
      cur <= load_word;
    end else if (step && (cur.cnt != '0)) begin
      if (cur.cnt == CNT_W'(1)) begin
        cur.cnt  <= '0;
        cur.mode <= '0;
      end else begin
        cur.cnt <= cur.cnt - CNT_W'(1);
      end
    end
  end

  logic quiet;
  assign quiet = step && !restore_en && !load_en;

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (cur == '0));

  assert_restore_load_R10: assert property (@(posedge clk) disable iff (rst)
    restore_en |=> (cur == $past(restore_word)));

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (quiet && cur.cnt > CNT_W'(1)) |=>
      (cur.cnt == $past(cur.cnt) - CNT_W'(1)) && (cur.mode == $past(cur.mode)));

  assert_persist_R3: assert property (@(posedge clk) disable iff (rst)
    (quiet && cur.cnt == '0) |=> $stable(cur));

  assert_expire_R4: assert property (@(posedge clk) disable iff (rst)
    (quiet && cur.cnt == CNT_W'(1)) |=> (cur.cnt == '0) && (cur.mode == '0));
endmodule

// File: rtl/mode_countdown_ctrl.sv
module mode_countdown_ctrl
  import mcd_pkg::*;
#(
  parameter logic [MODE_W-1:0] SUPPORTED = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              retire,
  input  logic              redirect,
  input  logic [MODE_W-1:0] need_mode,
  input  logic              restore_en,
  input  logic [REG_W-1:0]  restore_data,
  output logic [MODE_W-1:0] mode_out,
  output logic [REG_W-1:0]  save_word,
  output logic              trap_req
);
  mcd_word_t cur;
  logic      trap_q;
  logic      retire_live;
  logic      illegal;
  logic      step;

  // a retire counts only outside the trap cycle and not alongside a write or restore
  assign retire_live = retire && !trap_q && !wr_en && !restore_en;

  mcd_illegal #(.SUPPORTED(SUPPORTED)) u_illegal (
    .instr_ok  (retire_live),
    .redirect  (redirect),
    .need_mode (need_mode),
    .cur_mode  (cur.mode),
    .cur_cnt   (cur.cnt),
    .illegal   (illegal)
  );

  assign step = retire_live && !illegal;

  mcd_state u_state (
    .clk          (clk),
    .rst          (rst),
    .restore_en   (restore_en),
    .restore_word (mcd_word_t'(restore_data)),
    .load_en      (wr_en),
    .load_word    (mcd_word_t'(wr_data)),
    .step         (step),
    .cur          (cur)
  );

  always_ff @(posedge clk) begin
    if (rst) trap_q <= 1'b0;
    else     trap_q <= illegal;
  end

  assign mode_out  = cur.mode;
  assign save_word = cur;
  assign trap_req  = trap_q;

  assert_trap_single_R9: assert property (@(posedge clk) disable iff (rst)
    trap_q |=> !trap_q);

  assert_trap_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (trap_q && !wr_en && !restore_en) |=> $stable(cur));

  assert_redirect_trap_R6: assert property (@(posedge clk) disable iff (rst)
    (retire_live && redirect && cur.cnt != '0) |=> (trap_q && $stable(cur)));

  assert_unsup_need_R7: assert property (@(posedge clk) disable iff (rst)
    (retire_live && |(need_mode & ~SUPPORTED)) |=> trap_q);

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !restore_en) |=> (!trap_q && cur == $past(wr_data)));
endmodule

// File: tb/mode_countdown_ctrl_bench.sv
module mode_countdown_ctrl_bench;
  localparam logic [7:0] SUP = 8'h0F;

  logic        clk = 1'b0;
  logic        rst, wr_en, retire, redirect, restore_en;
  logic [31:0] wr_data, restore_data;
  logic [7:0]  need_mode;
  logic [7:0]  mode_out;
  logic [31:0] save_word;
  logic        trap_req;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mode_countdown_ctrl #(.SUPPORTED(SUP)) u_mode_countdown_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .retire(retire), .redirect(redirect), .need_mode(need_mode),
    .restore_en(restore_en), .restore_data(restore_data),
    .mode_out(mode_out), .save_word(save_word), .trap_req(trap_req)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; retire = 0; redirect = 0; restore_en = 0; need_mode = '0;
  endtask

  task automatic write_word(input logic [31:0] w);
    idle(); wr_en = 1; wr_data = w; tick(); wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    idle(); wr_data = '0; restore_data = '0;
    rst = 1; tick(); tick(); rst = 0;
    chk("R1 word", save_word, 32'h0);
    chk("R1 trap", {31'h0, trap_req}, 32'h0);
    chk("R1 mode", {24'h0, mode_out}, 32'h0);

    write_word(32'hABCD_0305);
    chk("R2 word", save_word, 32'hABCD_0305);
    chk("R2 mode", {24'h0, mode_out}, 32'h05);

    // countdown sweep with stalls between retires
    for (int n = 1; n <= 12; n++) begin
      write_word({16'h5A00, 8'(n), 8'h03});
      for (int k = 1; k <= n; k++) begin
        retire = 1; tick(); retire = 0;
        if (k == n) begin
          chk("R4 expire", save_word, 32'h5A00_0000);
        end else begin
          chk("R3 decrement", save_word, {16'h5A00, 8'(n - k), 8'h03});
        end
        tick();
        chk("R3 stall", save_word, (k == n) ? 32'h5A00_0000 : {16'h5A00, 8'(n - k), 8'h03});
      end
    end

    // persistent mode
    write_word(32'h0000_0003);
    retire = 1; repeat (5) tick(); retire = 0;
    chk("R3 persistent", save_word, 32'h0000_0003);

    // arming instruction not counted
    idle(); wr_en = 1; retire = 1; wr_data = 32'h0000_0402; tick(); idle();
    chk("R5 write+retire", save_word, 32'h0000_0402);
    idle(); wr_en = 1; retire = 1; redirect = 1; need_mode = 8'hFF;
    wr_data = 32'h0000_0401; tick(); idle();
    chk("R5 no trap", {31'h0, trap_req}, 32'h0);
    chk("R5 loaded", save_word, 32'h0000_0401);

    // redirect during countdown
    write_word(32'h0000_0301);
    retire = 1; redirect = 1; tick();
    chk("R6 trap", {31'h0, trap_req}, 32'h1);
    chk("R9 pre-trap word", save_word, 32'h0000_0301);
    tick(); idle();
    chk("R9 single pulse", {31'h0, trap_req}, 32'h0);
    chk("R9 frozen", save_word, 32'h0000_0301);
    retire = 1; tick(); idle();
    chk("R3 after trap", save_word, 32'h0000_0201);
    write_word(32'h0000_0001);
    retire = 1; redirect = 1; tick(); idle();
    chk("R6 no trap persistent", {31'h0, trap_req}, 32'h0);

    // need_mode sweep against supported mask
    write_word(32'h0);
    for (int m = 0; m < 256; m++) begin
      retire = 1; need_mode = 8'(m); tick(); idle();
      chk("R7 need sweep", {31'h0, trap_req}, {31'h0, ((8'(m) & ~SUP) != 8'h0)});
      tick();
      chk("R9 clear", {31'h0, trap_req}, 32'h0);
    end

    // unsupported bit written
    write_word(32'h0000_0030);
    chk("R8 accepted", save_word, 32'h0000_0030);
    retire = 1; need_mode = 8'h00; tick(); idle();
    chk("R8 no dep", {31'h0, trap_req}, 32'h0);
    retire = 1; need_mode = 8'h01; tick(); idle();
    chk("R8 dep trap", {31'h0, trap_req}, 32'h1);
    tick();

    // restore priority
    idle(); restore_en = 1; restore_data = 32'h1234_0207; wr_en = 1; wr_data = 32'hFFFF_FFFF;
    retire = 1; tick(); idle();
    chk("R10 priority", save_word, 32'h1234_0207);
    retire = 1; redirect = 1; tick(); idle();
    held = save_word;
    chk("R9 save", held, 32'h1234_0207);
    restore_en = 1; restore_data = 32'h0000_0506; tick(); idle();
    chk("R10 in trap cycle", save_word, 32'h0000_0506);
    restore_en = 1; restore_data = held; tick(); idle();
    chk("R10 round trip", save_word, 32'h1234_0207);
    retire = 1; tick(); idle();
    chk("R3 resumed", save_word, 32'h1234_0107);

    rst = 1; tick(); rst = 0;
    chk("R1 re-reset", save_word, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule